// File: doc/BRIEF.md
# Interrupt Unit Command and Register Interface

This block is the byte-wide programming interface of a single eight-input interrupt unit. A one-bit address selects between a command port and a data port. Writes to the command port start the initialization word sequence, change operating modes, or issue end-of-interrupt and priority-rotation commands. Writes to the data port either load the input mask or, during initialization, supply the vector base and the optional trailing configuration words. A separate write strobe loads a per-input trigger-mode register. Only the bits that a fixed, instance-dependent mask allows can be written.

The request and in-service vectors are held by a neighbouring resolver, which feeds them in. This block uses them to answer status reads and poll reads, and to find the highest-priority in-service input for non-specific end-of-interrupt. It drives back to the resolver the mask, the vector base, the rotation base, the mode flags, and one-cycle pulses that clear in-service and request bits. It also drives a pulse that clears the resolver on initialization. All state changes at the clock edge on which a strobe is high. Read data is combinational from the current state.

Priority is rotating. With rotation base b, input (b+k) mod 8 has rank k, and the lowest rank wins.

Top module: `pic_cmd_if`

## Requirements
- R1: After reset, mask, vector base, rotation base, trigger mode, all mode flags and all clear pulses are zero, and a read of address 0 returns the request vector.
- R2: A write to address 0 with bit 4 set does the following on the next cycle: it clears mask, vector base, rotation base and all mode flags, cancels a pending poll, selects the request vector for reads, and pulses init_clr for one cycle. Bit 0 of that byte records whether a fourth word is expected.
- R3: After an initialization write, the next address-1 write loads the vector base with bits 2:0 forced to zero. The address-1 write after that is consumed without effect. If a fourth word was requested, the next address-1 write then sets special nesting from bit 4 and auto-EOI from bit 1. After that, address-1 writes load the mask.
- R4: A write to address 0 with bit 4 clear and bit 3 set is a mode command. Bit 2 arms a poll. Bit 1 set lets bit 0 choose the read source (1 = in-service, 0 = request). Bit 6 set copies bit 5 into the special-mask flag.
- R5: A command write (address 0, bits 4 and 3 clear) with bits 7:5 equal to 0 or 4 sets rotate-on-auto-EOI to bit 7.
- R6: Command code 1 pulses isr_clr for the highest-priority set in-service bit. Command code 5 does the same and sets the rotation base to that input plus 1. With no in-service bit set, neither code has an effect.
- R7: Command code 3 pulses isr_clr for the input named by bits 2:0. Command code 7 does the same and also sets the rotation base to that input plus 1.
- R8: Command code 6 sets the rotation base to bits 2:0 plus 1 (mod 8). Command code 2 changes nothing.
- R9: While a poll is armed, read data is the winning input number, or 7 when there is none. A request wins when it is unmasked, has the best rank, and ranks better than every in-service bit. On the master, input 2 is excluded from the in-service bits when special nesting is on. A read strobe with a winner pulses both isr_clr and irr_clr for that input. Any read strobe disarms the poll.
- R10: Without an armed poll, address 1 reads the mask, and address 0 reads the in-service or request vector according to the read select.
- R11: A trigger-mode write stores the data ANDed with 0xF8 on the master instance and 0xDE on the slave instance.
- R12: isr_clr carries at most one bit. isr_clr, irr_clr and init_clr are zero in any cycle that follows a cycle with no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 1 | Port select: 0 command, 1 data |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe for the command/data ports |
| rd_en | input | 1 | Read strobe (consumes an armed poll) |
| trig_we | input | 1 | Write strobe for the trigger-mode register |
| req_vec | input | 8 | Request vector from the resolver |
| isr_vec | input | 8 | In-service vector from the resolver |
| rdata | output | 8 | Read data |
| mask_o | output | 8 | Input mask |
| vec_base | output | 8 | Vector base, bits 2:0 zero |
| rot_base | output | 3 | Rotation base (input with rank 0) |
| trig_mode | output | 8 | Per-input trigger mode |
| auto_eoi | output | 1 | Auto end-of-interrupt flag |
| rot_aeoi | output | 1 | Rotate-on-auto-EOI flag |
| spec_nest | output | 1 | Special nesting flag |
| spec_mask | output | 1 | Special mask flag |
| init_clr | output | 1 | One-cycle pulse: resolver clears request and in-service state |
| isr_clr | output | 8 | One-cycle in-service clear request |
| irr_clr | output | 8 | One-cycle request clear request |

## Verification
The properties assume that wr_en and rd_en are never high in the same cycle, so that a command write and a poll read cannot both try to drive the clear pulses. They also assume that req_vec and isr_vec are settled values from the resolver. The random stimulus picks exactly one of write, read or idle on each cycle, with trig_we chosen independently. It draws fresh request and in-service vectors every cycle, so poll and non-specific end-of-interrupt results vary with rotation base and mask. Directed sequences cover the three- and four-word initialization paths and each command code.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;
   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_BASE = 2'd1,
      ST_W3   = 2'd2,
      ST_W4   = 2'd3
   } init_st_t;

   localparam logic [2:0] CMD_RAE0  = 3'd0;
   localparam logic [2:0] CMD_NSEOI = 3'd1;
   localparam logic [2:0] CMD_NOP   = 3'd2;
   localparam logic [2:0] CMD_SEOI  = 3'd3;
   localparam logic [2:0] CMD_RAE1  = 3'd4;
   localparam logic [2:0] CMD_RNEOI = 3'd5;
   localparam logic [2:0] CMD_SETPR = 3'd6;
   localparam logic [2:0] CMD_RSEOI = 3'd7;
endpackage

// File: rtl/pic_prio_find.sv
module pic_prio_find #(
   parameter int N  = 8,
   parameter int IW = $clog2(N)
) (
   input  logic [N-1:0]  vec,
   input  logic [IW-1:0] base,
   output logic          found,
   output logic [IW-1:0] idx,
   output logic [IW:0]   rank
);
   logic [IW-1:0] j;
   always_comb begin
      found = 1'b0;
      idx   = '0;
      rank  = (IW+1)'(N);
      j     = '0;
      for (int k = N - 1; k >= 0; k--) begin
         j = base + IW'(k);
         if (vec[j]) begin
            found = 1'b1;
            idx   = j;
            rank  = (IW+1)'(k);
         end
      end
   end
endmodule

// File: rtl/pic_trig_reg.sv
module pic_trig_reg #(
   parameter int N         = 8,
   parameter bit IS_MASTER = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [N-1:0] wdata,
   output logic [N-1:0] q
);
   logic [N-1:0] wmask;
   generate
      if (IS_MASTER) begin : g_master
         assign wmask = N'(8'hF8);
      end else begin : g_slave
         assign wmask = N'(8'hDE);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= wdata & wmask;
   end
endmodule

// File: rtl/pic_cmd_if.sv
module pic_cmd_if
   import pic_cmd_pkg::*;
#(
   parameter int N_IN       = 8,
   parameter int DATA_W     = 8,
   parameter bit IS_MASTER  = 1'b1,
   parameter int CASCADE_IN = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic              trig_we,
   input  logic [N_IN-1:0]   req_vec,
   input  logic [N_IN-1:0]   isr_vec,
   output logic [DATA_W-1:0] rdata,
   output logic [N_IN-1:0]   mask_o,
   output logic [DATA_W-1:0] vec_base,
   output logic [$clog2(N_IN)-1:0] rot_base,
   output logic [N_IN-1:0]   trig_mode,
   output logic              auto_eoi,
   output logic              rot_aeoi,
   output logic              spec_nest,
   output logic              spec_mask,
   output logic              init_clr,
   output logic [N_IN-1:0]   isr_clr,
   output logic [N_IN-1:0]   irr_clr
);
   localparam int IW = $clog2(N_IN);

   generate
      if (N_IN != (1 << IW) || N_IN != DATA_W || DATA_W < 8) begin : g_bad_cfg
         $error("pic_cmd_if: N_IN must be a power of two equal to DATA_W (>= 8)");
      end
      if (CASCADE_IN >= N_IN) begin : g_bad_casc
         $error("pic_cmd_if: CASCADE_IN out of range");
      end
   endgenerate

   init_st_t      st_q;
   logic          need4_q, poll_q, rsel_q;

   logic wr_cmd, wr_dat, is_init, is_mode, is_ocw;
   logic [2:0] cmd;
   assign wr_cmd  = wr_en & ~addr;
   assign wr_dat  = wr_en & addr;
   assign is_init = wr_cmd & wdata[4];
   assign is_mode = wr_cmd & ~wdata[4] & wdata[3];
   assign is_ocw  = wr_cmd & ~wdata[4] & ~wdata[3];
   assign cmd     = wdata[7:5];

   // priority resolution against the current rotation base
   logic [N_IN-1:0] req_eff, isr_eff, nest_excl;
   assign nest_excl = (IS_MASTER && spec_nest) ? (N_IN'(1) << CASCADE_IN) : '0;
   assign req_eff   = req_vec & ~mask_o;
   assign isr_eff   = isr_vec & ~nest_excl;

   logic          rq_found, is_found, eo_found;
   logic [IW-1:0] rq_idx, is_idx, eo_idx;
   logic [IW:0]   rq_rank, is_rank, eo_rank;

   pic_prio_find #(.N(N_IN), .IW(IW)) u_req (
      .vec(req_eff), .base(rot_base), .found(rq_found), .idx(rq_idx), .rank(rq_rank));
   pic_prio_find #(.N(N_IN), .IW(IW)) u_cur (
      .vec(isr_eff), .base(rot_base), .found(is_found), .idx(is_idx), .rank(is_rank));
   pic_prio_find #(.N(N_IN), .IW(IW)) u_eoi (
      .vec(isr_vec), .base(rot_base), .found(eo_found), .idx(eo_idx), .rank(eo_rank));

   logic win_ok;
   assign win_ok = rq_found && (rq_rank < is_rank);

   pic_trig_reg #(.N(N_IN), .IS_MASTER(IS_MASTER)) u_trig (
      .clk(clk), .rst_n(rst_n), .we(trig_we), .wdata(wdata), .q(trig_mode));

   always_comb begin
      if (poll_q)
         rdata = win_ok ? DATA_W'(rq_idx) : DATA_W'(N_IN - 1);
      else if (addr)
         rdata = mask_o;
      else
         rdata = rsel_q ? isr_vec : req_vec;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_RUN;
         need4_q   <= 1'b0;
         poll_q    <= 1'b0;
         rsel_q    <= 1'b0;
         mask_o    <= '0;
         vec_base  <= '0;
         rot_base  <= '0;
         auto_eoi  <= 1'b0;
         rot_aeoi  <= 1'b0;
         spec_nest <= 1'b0;
         spec_mask <= 1'b0;
         init_clr  <= 1'b0;
         isr_clr   <= '0;
         irr_clr   <= '0;
      end else begin
         init_clr <= 1'b0;
         isr_clr  <= '0;
         irr_clr  <= '0;
         if (is_init) begin
            st_q      <= ST_BASE;
            need4_q   <= wdata[0];
            poll_q    <= 1'b0;
            rsel_q    <= 1'b0;
            mask_o    <= '0;
            vec_base  <= '0;
            rot_base  <= '0;
            auto_eoi  <= 1'b0;
            rot_aeoi  <= 1'b0;
            spec_nest <= 1'b0;
            spec_mask <= 1'b0;
            init_clr  <= 1'b1;
         end else if (is_mode) begin
            if (wdata[2]) poll_q    <= 1'b1;
            if (wdata[1]) rsel_q    <= wdata[0];
            if (wdata[6]) spec_mask <= wdata[5];
         end else if (is_ocw) begin
            unique case (cmd)
               CMD_RAE0, CMD_RAE1: rot_aeoi <= wdata[7];
               CMD_NSEOI, CMD_RNEOI: begin
                  if (eo_found) begin
                     isr_clr <= N_IN'(1) << eo_idx;
                     if (cmd == CMD_RNEOI) rot_base <= eo_idx + IW'(1);
                  end
               end
               CMD_SEOI:  isr_clr  <= N_IN'(1) << wdata[IW-1:0];
               CMD_SETPR: rot_base <= wdata[IW-1:0] + IW'(1);
               CMD_RSEOI: begin
                  isr_clr  <= N_IN'(1) << wdata[IW-1:0];
                  rot_base <= wdata[IW-1:0] + IW'(1);
               end
               CMD_NOP: ;
               default: ;
            endcase
         end
         if (wr_dat) begin
            unique case (st_q)
               ST_RUN:  mask_o <= wdata;
               ST_BASE: begin
                  vec_base <= {wdata[DATA_W-1:IW], {IW{1'b0}}};
                  st_q     <= ST_W3;
               end
               ST_W3:   st_q <= need4_q ? ST_W4 : ST_RUN;
               ST_W4: begin
                  spec_nest <= wdata[4];
                  auto_eoi  <= wdata[1];
                  st_q      <= ST_RUN;
               end
               default: st_q <= ST_RUN;
            endcase
         end
         if (rd_en && poll_q) begin
            poll_q <= 1'b0;
            if (win_ok) begin
               isr_clr <= N_IN'(1) << rq_idx;
               irr_clr <= N_IN'(1) << rq_idx;
            end
         end
      end
   end
endmodule

// File: rtl/pic_cmd_if_chk.sv
module pic_cmd_if_chk #(
   parameter int N_IN      = 8,
   parameter bit IS_MASTER = 1'b1
) (
   input logic            clk,
   input logic            rst_n,
   input logic            addr,
   input logic [7:0]      wdata,
   input logic            wr_en,
   input logic            rd_en,
   input logic            trig_we,
   input logic [N_IN-1:0] mask_o,
   input logic [7:0]      vec_base,
   input logic [2:0]      rot_base,
   input logic [N_IN-1:0] trig_mode,
   input logic            init_clr,
   input logic [N_IN-1:0] isr_clr,
   input logic [N_IN-1:0] irr_clr
);
   localparam logic [7:0] TMASK = IS_MASTER ? 8'hF8 : 8'hDE;

   // R2: initialization clears programmed state and pulses init_clr
   a_r2_init_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !addr && wdata[4]) |=> (init_clr && mask_o == '0 && vec_base == '0 && rot_base == '0));

   // R7: specific EOI targets the named input
   a_r7_specific_eoi: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !addr && wdata[7:3] == 5'b01100) |=> (isr_clr == (N_IN'(1) << $past(wdata[2:0]))));

   // R8: set-priority command loads rotation base with named input plus one
   a_r8_set_prio: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !addr && wdata[7:3] == 5'b11000) |=> (rot_base == 3'($past(wdata[2:0]) + 3'd1)));

   // R9: a request clear only comes from a poll, paired with the same in-service clear
   a_r9_poll_pair: assert property (@(posedge clk) disable iff (!rst_n)
      (irr_clr != '0) |-> (isr_clr == irr_clr && $past(rd_en)));

   // R11: trigger-mode write keeps only the permitted bits
   a_r11_trig_mask: assert property (@(posedge clk) disable iff (!rst_n)
      trig_we |=> (trig_mode == ($past(wdata) & TMASK)));

   // R12: clear pulses are single-bit and need a strobe in the prior cycle
   a_r12_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(isr_clr));
   a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !rd_en) |=> (isr_clr == '0 && irr_clr == '0 && !init_clr));
endmodule

bind pic_cmd_if pic_cmd_if_chk #(.N_IN(N_IN), .IS_MASTER(IS_MASTER)) u_chk (
   .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en),
   .trig_we(trig_we), .mask_o(mask_o), .vec_base(vec_base), .rot_base(rot_base),
   .trig_mode(trig_mode), .init_clr(init_clr), .isr_clr(isr_clr), .irr_clr(irr_clr));

// File: tb/tb_pic_cmd_if.sv
module tb_pic_cmd_if;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic       addr = 1'b0, wr_en = 1'b0, rd_en = 1'b0, trig_we = 1'b0;
   logic [7:0] wdata = '0, req_vec = '0, isr_vec = '0;
   logic [7:0] rdata, mask_o, vec_base, trig_mode, isr_clr, irr_clr;
   logic [2:0] rot_base;
   logic       auto_eoi, rot_aeoi, spec_nest, spec_mask, init_clr;
   logic [7:0] s_rdata, s_mask, s_base, s_trig, s_isrc, s_irrc;
   logic [2:0] s_rot;
   logic       s_ae, s_ra, s_sn, s_sm, s_ic;

   pic_cmd_if dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
      .rd_en(rd_en), .trig_we(trig_we), .req_vec(req_vec), .isr_vec(isr_vec), .rdata(rdata),
      .mask_o(mask_o), .vec_base(vec_base), .rot_base(rot_base), .trig_mode(trig_mode),
      .auto_eoi(auto_eoi), .rot_aeoi(rot_aeoi), .spec_nest(spec_nest), .spec_mask(spec_mask),
      .init_clr(init_clr), .isr_clr(isr_clr), .irr_clr(irr_clr));

   pic_cmd_if #(.IS_MASTER(1'b0)) dut_s (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
      .wr_en(wr_en), .rd_en(rd_en), .trig_we(trig_we), .req_vec(req_vec), .isr_vec(isr_vec),
      .rdata(s_rdata), .mask_o(s_mask), .vec_base(s_base), .rot_base(s_rot), .trig_mode(s_trig),
      .auto_eoi(s_ae), .rot_aeoi(s_ra), .spec_nest(s_sn), .spec_mask(s_sm), .init_clr(s_ic),
      .isr_clr(s_isrc), .irr_clr(s_irrc));

   int n_chk = 0, n_bad = 0;

   // reference state
   logic [7:0] m_mask = 0, m_base = 0, m_trig = 0, m_strig = 0, m_isrc = 0, m_irrc = 0;
   logic [2:0] m_rot = 0;
   logic [1:0] m_st = 0;
   logic m_need4 = 0, m_poll = 0, m_rsel = 0, m_ae = 0, m_ra = 0, m_sn = 0, m_sm = 0, m_ic = 0;

   task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   function automatic int rank_of(input logic [7:0] v, input logic [2:0] rb);
      for (int k = 0; k < 8; k++) if (v[(rb + k) % 8]) return k;
      return 8;
   endfunction

   function automatic int winner();
      logic [7:0] iv = isr_vec;
      int pr, pc;
      if (m_sn) iv[2] = 1'b0;
      pr = rank_of(req_vec & ~m_mask, m_rot);
      pc = rank_of(iv, m_rot);
      return (pr < pc) ? int'((m_rot + pr) % 8) : -1;
   endfunction

   function automatic logic [7:0] exp_rdata();
      int w;
      if (m_poll) begin
         w = winner();
         return (w >= 0) ? 8'(w) : 8'd7;
      end
      if (addr) return m_mask;
      return m_rsel ? isr_vec : req_vec;
   endfunction

   task automatic model_update();
      int w, r;
      m_isrc = 0; m_irrc = 0; m_ic = 0;
      if (trig_we) begin m_trig = wdata & 8'hF8; m_strig = wdata & 8'hDE; end
      if (wr_en && !addr) begin
         if (wdata[4]) begin
            m_st = 1; m_need4 = wdata[0]; m_poll = 0; m_rsel = 0; m_mask = 0; m_base = 0;
            m_rot = 0; m_ae = 0; m_ra = 0; m_sn = 0; m_sm = 0; m_ic = 1;
         end else if (wdata[3]) begin
            if (wdata[2]) m_poll = 1;
            if (wdata[1]) m_rsel = wdata[0];
            if (wdata[6]) m_sm = wdata[5];
         end else begin
            case (wdata[7:5])
               3'd0, 3'd4: m_ra = wdata[7];
               3'd1, 3'd5: begin
                  r = rank_of(isr_vec, m_rot);
                  if (r < 8) begin
                     m_isrc = 8'd1 << ((m_rot + r) % 8);
                     if (wdata[7:5] == 3'd5) m_rot = 3'((m_rot + r + 1) % 8);
                  end
               end
               3'd3: m_isrc = 8'd1 << wdata[2:0];
               3'd6: m_rot = wdata[2:0] + 3'd1;
               3'd7: begin m_isrc = 8'd1 << wdata[2:0]; m_rot = wdata[2:0] + 3'd1; end
               default: ;
            endcase
         end
      end
      if (wr_en && addr) begin
         case (m_st)
            2'd0: m_mask = wdata;
            2'd1: begin m_base = wdata & 8'hF8; m_st = 2; end
            2'd2: m_st = m_need4 ? 2'd3 : 2'd0;
            default: begin m_sn = wdata[4]; m_ae = wdata[1]; m_st = 0; end
         endcase
      end
      if (rd_en && m_poll) begin
         w = winner();
         m_poll = 0;
         if (w >= 0) begin m_isrc = 8'd1 << w; m_irrc = 8'd1 << w; end
      end
   endtask

   task automatic check_outs(input string tag);
      check(mask_o == m_mask, "R3 mask", mask_o, m_mask);
      check(vec_base == m_base, "R3 base", vec_base, m_base);
      check(rot_base == m_rot, "R8 rotation base", 8'(rot_base), 8'(m_rot));
      check(trig_mode == m_trig, "R11 master trigger", trig_mode, m_trig);
      check(s_trig == m_strig, "R11 slave trigger", s_trig, m_strig);
      check({auto_eoi, spec_nest} == {m_ae, m_sn}, "R3 fourth word flags",
            8'({auto_eoi, spec_nest}), 8'({m_ae, m_sn}));
      check(spec_mask == m_sm, "R4 special mask", 8'(spec_mask), 8'(m_sm));
      check(rot_aeoi == m_ra, "R5 rotate on auto-EOI", 8'(rot_aeoi), 8'(m_ra));
      check(init_clr == m_ic, "R2 init pulse", 8'(init_clr), 8'(m_ic));
      check(isr_clr == m_isrc, {tag, " isr_clr"}, isr_clr, m_isrc);
      check(irr_clr == m_irrc, "R9 irr_clr", irr_clr, m_irrc);
   endtask

   // one cycle: drive at negedge, check read data, model the edge, check outputs
   task automatic step(input bit w, input bit r, input bit a, input logic [7:0] d,
                       input bit tw, input logic [7:0] rq, input logic [7:0] is, input string tag);
      wr_en = w; rd_en = r; addr = a; wdata = d; trig_we = tw; req_vec = rq; isr_vec = is;
      #1;
      check(rdata == exp_rdata(), m_poll ? "R9 poll read" : "R10 read data", rdata, exp_rdata());
      model_update();
      @(posedge clk);
      @(negedge clk);
      wr_en = 0; rd_en = 0; trig_we = 0;
      check_outs(tag);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      req_vec = 8'h5A;
      #1;
      check(rdata == 8'h5A, "R1 reset read", rdata, 8'h5A);
      check_outs("R1");
      // R2/R3 four-word initialization
      step(1, 0, 0, 8'h11, 0, 0, 0, "R2");
      step(1, 0, 1, 8'h4D, 0, 0, 0, "R3");
      step(1, 0, 1, 8'h00, 0, 0, 0, "R3");
      step(1, 0, 1, 8'h12, 0, 0, 0, "R3");
      step(1, 0, 1, 8'hA5, 0, 0, 0, "R3");
      // three-word initialization
      step(1, 0, 0, 8'h10, 0, 0, 0, "R2");
      step(1, 0, 1, 8'h20, 0, 0, 0, "R3");
      step(1, 0, 1, 8'hFF, 0, 0, 0, "R3");
      step(1, 0, 1, 8'h0F, 0, 0, 0, "R3");
      step(0, 0, 1, 8'h00, 0, 0, 0, "R10");
      // R4 read select and special mask
      step(1, 0, 0, 8'h0B, 0, 8'h03, 8'h30, "R4");
      step(0, 0, 0, 8'h00, 0, 8'h03, 8'h30, "R10");
      step(1, 0, 0, 8'h68, 0, 0, 0, "R4");
      // R5
      step(1, 0, 0, 8'h80, 0, 0, 0, "R5");
      step(1, 0, 0, 8'h00, 0, 0, 0, "R5");
      // R6 non-specific and rotating EOI
      step(1, 0, 0, 8'h20, 0, 0, 8'h50, "R6");
      step(1, 0, 0, 8'hA0, 0, 0, 8'h50, "R6");
      step(1, 0, 0, 8'h20, 0, 0, 8'h00, "R6");
      // R7 specific EOI
      step(1, 0, 0, 8'h65, 0, 0, 0, "R7");
      step(1, 0, 0, 8'hE2, 0, 0, 0, "R7");
      // R8 set priority and no-op
      step(1, 0, 0, 8'hC7, 0, 0, 0, "R8");
      step(1, 0, 0, 8'h40, 0, 0, 8'hFF, "R8");
      // R9 poll with winner, then with none
      step(1, 0, 0, 8'h0C, 0, 0, 0, "R9");
      step(0, 1, 0, 8'h00, 0, 8'h90, 8'h00, "R9");
      step(1, 0, 0, 8'h0C, 0, 0, 0, "R9");
      step(0, 1, 0, 8'h00, 0, 8'h00, 8'h00, "R9");
      // R11 trigger register
      step(0, 0, 0, 8'hFF, 1, 0, 0, "R11");
      // R12 idle
      step(0, 0, 0, 8'h00, 0, 8'hFF, 8'hFF, "R12");
      // constrained random mix
      for (int i = 0; i < 2000; i++) begin
         int sel = $urandom_range(0, 9);
         logic [7:0] d = 8'($urandom);
         logic [7:0] rq = 8'($urandom);
         logic [7:0] is = 8'($urandom & $urandom & $urandom);
         bit tw = ($urandom_range(0, 9) == 0);
         if (sel == 0 && $urandom_range(0, 3) != 0) d[4] = 1'b0;
         if (sel <= 4)      step(1, 0, 1'(sel > 1), d, tw, rq, is, "R6");
         else if (sel <= 7) step(0, 1, 1'($urandom), d, tw, rq, is, "R9");
         else               step(0, 0, 1'($urandom), d, tw, rq, is, "R12");
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL R1 watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule